// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block keeps the byte address of the instruction being executed and works out, from the current 32-bit instruction word, where execution goes next. There are three outcomes. Most instructions simply move on to the following word. A not-equal conditional branch jumps by a signed word displacement when its two compare operands differ. An unconditional jump replaces the low part of the address with a word index taken from the instruction.

The pipeline front end feeds the instruction and both compare operands that have already been read from the register file. It raises the step enable once for each instruction it retires. The sequencer shows the current address and a redirect flag. The flag tells fetch that the next address does not follow on sequentially.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset loads the address register with 0. Reset takes priority over the step enable and over any instruction.
- R2: While the step enable is low, the address keeps its value and the redirect flag stays low, whatever the instruction is.
- R3: On a step, any opcode (bits 31:26) other than 5 or 2 advances the address by 4 and leaves the redirect flag low.
- R4: When opcode 5 is stepped with unequal compare operands, the branch is taken. The next address is (address + 4) + (bits 15:0 sign-extended and multiplied by 4), and the redirect flag is high during that cycle.
- R5: When opcode 5 is stepped with equal compare operands, the address advances by 4 and the redirect flag stays low.
- R6: A negative branch displacement (bit 15 set) moves the address backwards. The sum wraps modulo 2^32.
- R7: When opcode 2 is stepped, the next address is formed from three parts, from high bits to low: bits 31:28 of (address + 4), then instruction bits 25:0, then two zero bits. The redirect flag is high during that cycle.
- R8: The high four bits of a jump come from address + 4, not from the current address. A jump placed in the last word of a 256 MiB region therefore lands in the next region.
- R9: The redirect flag is combinational. It reflects the instruction presented in the same cycle as the step that it redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Commit the next address at this edge |
| instr | input | 32 | Current instruction word |
| cmp_a | input | 32 | First branch compare operand |
| cmp_b | input | 32 | Second branch compare operand |
| pc_q | output | 32 | Current byte address |
| redirect | output | 1 | Next address is not sequential |

## Verification
Branches are driven with equal and with unequal operands, using the same displacement each time, so that a wrong compare shows up as a sequential versus a non-sequential step. Displacements of both signs are used, which separates correct sign extension from zero extension. Jumps are issued from inside a region and from its final word, which shows whether the high bits come from the current address or from the incremented one. A long mixed stream of random opcodes, operands and enable gaps is then checked against a behavioural model on every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned OPC_W   = 6,
  parameter int unsigned OP_BNE  = 5,
  parameter int unsigned OP_JUMP = 2
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  cmp_a,
  input  logic [XLEN-1:0]  cmp_b,
  input  logic             step_en,
  output nxt_sel_e         sel,
  output logic             redirect
);
  logic is_bne, is_jump, ops_differ;

  assign is_bne     = (opcode == OPC_W'(OP_BNE));
  assign is_jump    = (opcode == OPC_W'(OP_JUMP));
  assign ops_differ = (cmp_a != cmp_b);

  always_comb begin
    if (is_jump)                  sel = NXT_JUMP;
    else if (is_bne && ops_differ) sel = NXT_BRANCH;
    else                          sel = NXT_SEQ;
  end

  assign redirect = step_en && (sel != NXT_SEQ);
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned TGT_W = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);
  localparam int unsigned HI_W  = XLEN - TGT_W - 2;
  localparam int unsigned EXT_W = XLEN - OFF_W - 2;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] p);
    return p + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0] p4,
                                               input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    return p4 + disp;
  endfunction

  function automatic logic [XLEN-1:0] f_jump(input logic [XLEN-1:0] p4,
                                             input logic [TGT_W-1:0] tgt);
    return {p4[XLEN-1 -: HI_W], tgt, 2'b00};
  endfunction

  assign seq_pc = f_seq(pc);
  assign br_pc  = f_branch(seq_pc, instr[OFF_W-1:0]);
  assign jmp_pc = f_jump(seq_pc, instr[TGT_W-1:0]);
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned XLEN    = 32,
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import npc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned OPC_W   = 6,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned TGT_W   = 26,
  parameter int unsigned OP_BNE  = 5,
  parameter int unsigned OP_JUMP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output logic [XLEN-1:0] pc_q,
  output logic            redirect
);
  localparam int unsigned HI_W = XLEN - TGT_W - 2;

  nxt_sel_e        sel;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, pc_next;
  logic [OPC_W-1:0] opcode;

  assign opcode = instr[XLEN-1 -: OPC_W];

  npc_decode #(.XLEN(XLEN), .OPC_W(OPC_W), .OP_BNE(OP_BNE), .OP_JUMP(OP_JUMP)) u_decode (
    .opcode(opcode), .cmp_a(cmp_a), .cmp_b(cmp_b), .step_en(step_en),
    .sel(sel), .redirect(redirect)
  );

  npc_targets #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_targets (
    .pc(pc_q), .instr(instr), .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  always_comb begin
    unique case (sel)
      NXT_BRANCH: pc_next = br_pc;
      NXT_JUMP:   pc_next = jmp_pc;
      default:    pc_next = seq_pc;
    endcase
  end

  npc_pc_reg #(.XLEN(XLEN), .RST_VAL('0)) u_pc_reg (
    .clk(clk), .rst(rst), .en(step_en), .d(pc_next), .q(pc_q)
  );

  // R2: no step, no movement
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc_q));

  // R2: no redirect without a step
  a_r2_no_redirect_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |-> !redirect);

  // R3: a step without redirect is a plain increment
  a_r3_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (step_en && !redirect) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R5: equal operands never redirect
  a_r5_equal_not_taken: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_W'(OP_BNE) && cmp_a == cmp_b) |-> !redirect);

  // R7 / R8: jump keeps upper bits of the incremented address, word aligned
  a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
    (step_en && opcode == OPC_W'(OP_JUMP)) |=>
      (pc_q[XLEN-1 -: HI_W] == $past(seq_pc[XLEN-1 -: HI_W])) && (pc_q[1:0] == 2'b00));
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_en;
  logic [31:0] instr, cmp_a, cmp_b;
  logic [31:0] pc_q;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .pc_q(pc_q), .redirect(redirect)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check redirect, then check the address after the edge.
  task automatic step(input string req, input logic en, input logic [5:0] op,
                      input logic [25:0] body, input logic [31:0] a, input logic [31:0] b);
    logic exp_redir;
    int   off;
    logic [31:0] nxt;
    @(negedge clk);
    step_en = en; instr = {op, body}; cmp_a = a; cmp_b = b;
    exp_redir = en && (op == 6'd2 || (op == 6'd5 && a != b));
    off = $signed(body[15:0]);
    if (!en)               nxt = exp_pc;
    else if (op == 6'd2)   nxt = ((exp_pc + 32'd4) & 32'hF000_0000) | (32'(body) * 4);
    else if (exp_redir)    nxt = exp_pc + 32'd4 + 32'(off * 4);
    else                   nxt = exp_pc + 32'd4;
    #1 check32({req, " redirect"}, {31'd0, redirect}, {31'd0, exp_redir});
    @(posedge clk); #1;
    exp_pc = nxt;
    check32({req, " pc"}, pc_q, exp_pc);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; step_en = 1'b0; instr = '0; cmp_a = '0; cmp_b = '0;
    repeat (3) @(posedge clk);
    #1 check32("R1 reset", pc_q, 32'd0);
    check32("R1 redirect in reset", {31'd0, redirect}, 32'd0);
    @(negedge clk); rst = 1'b0;
    exp_pc = 32'd0;

    step("R3 opcode 0",            1'b1, 6'd0, 26'h123456, 32'd1, 32'd2);
    step("R2 idle jump",           1'b0, 6'd2, 26'h3FF, 32'd0, 32'd0);
    step("R2 idle branch",         1'b0, 6'd5, 26'h0003, 32'd1, 32'd2);
    step("R4 bne taken +3",        1'b1, 6'd5, 26'h0003, 32'd7, 32'd9);
    step("R5 bne equal",           1'b1, 6'd5, 26'h0003, 32'd9, 32'd9);
    step("R6 bne back -2",         1'b1, 6'd5, 26'h0FFFE, 32'd0, 32'h8000_0000);
    step("R3 opcode 4",            1'b1, 6'd4, 26'h0FFFE, 32'd1, 32'd5);
    step("R7 jump to region end",  1'b1, 6'd2, 26'h3FF_FFFF, 32'd0, 32'd0);
    step("R8 jump crosses region", 1'b1, 6'd2, 26'h000_0005, 32'd0, 32'd0);
    step("R6 wrap below region",   1'b1, 6'd5, 26'h0_8000, 32'd3, 32'd4);

    // R1: reset wins over a jump being stepped
    @(negedge clk); rst = 1'b1; step_en = 1'b1; instr = {6'd2, 26'h155};
    @(posedge clk); #1 check32("R1 reset over jump", pc_q, 32'd0);
    @(negedge clk); rst = 1'b0; step_en = 1'b0; exp_pc = 32'd0;

    // R9 with mixed stream
    for (int k = 0; k < 300; k++) begin
      logic [5:0]  op;
      logic [31:0] a, b;
      int sel;
      sel = $urandom_range(0, 4);
      op  = (sel == 0) ? 6'd2 : (sel <= 2) ? 6'd5 : 6'($urandom_range(0, 63));
      a   = 32'($urandom_range(0, 3));
      b   = 32'($urandom_range(0, 3));
      step("R9 mixed stream", ($urandom_range(0, 4) != 0), op, 26'($urandom), a, b);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule